// File: doc/BRIEF.md
# Ethernet Receive Destination Filter

This block decides, once per received frame, whether the frame should be kept or thrown away. It looks only at the 48-bit destination address and the frame length. A frame is kept when it is long enough and its destination passes at least one enabled test. The tests are an exact compare against either of two programmed station addresses, a compare against the all-ones broadcast address, and a lookup in a 64-entry group hash table indexed by a 6-bit fold of the address.

The receive path presents the address and length with a one-cycle strobe. One clock later the block returns a registered decision with its own valid strobe. The station addresses, hash table and enable bits arrive on static configuration inputs. The block copies them into reset-cleared shadow registers on every clock, so a new setting takes effect for strobes one cycle after it is driven. Until it is configured, the block drops every frame.

Top module: `rx_addr_filter`

## Requirements
- R1: A frame whose length input is below 12 bytes is always dropped, whatever its address; a length of exactly 12 bytes is eligible.
- R2: Every cycle with `frm_valid` high yields `dec_valid` high on the next cycle and on no other cycle; `dec_accept` is never high while `dec_valid` is low.
- R3: Control bit 0 enables station address 0 and bit 1 enables station address 1. An enabled station accepts a frame whose destination equals it exactly. Each station is given as a low word holding address bytes 0..3, with byte 0 in bits 7:0, and a 16-bit high word holding bytes 4..5, with byte 4 in bits 7:0. `frm_dst` carries byte 0 in bits 7:0 and byte 5 in bits 47:40.
- R4: With control bit 3 set, a destination of all ones is accepted; with it clear, broadcast gets no special treatment.
- R5: The hash index is the XOR of eight 6-bit groups that are cut from the address bit stream. The stream starts at bit 0 of byte 0, so group g is `frm_dst[6g+5:6g]`.
- R6: A hash index of 32 or more selects bit (index-32) of `grp_tbl_hi`; a smaller index selects bit index of `grp_tbl_lo`; a selected set bit accepts the frame.
- R7: A destination with bit 0 of byte 0 clear (individual address) may match by hash only when control bit 2 is set; group addresses always take part in the hash test.
- R8: The configuration inputs are registered before use. A strobe is judged with the configuration present one cycle earlier, and the registered configuration is all zeros after reset.
- R9: While reset is held and in the first cycle after it, `dec_valid` and `dec_accept` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_valid | input | 1 | One-cycle strobe: destination and length are valid |
| frm_dst | input | 48 | Destination address, byte 0 in bits 7:0 |
| frm_len | input | 16 | Frame length in bytes |
| sta0_lo | input | 32 | Station 0 address bytes 0..3 |
| sta0_hi | input | 16 | Station 0 address bytes 4..5 |
| sta1_lo | input | 32 | Station 1 address bytes 0..3 |
| sta1_hi | input | 16 | Station 1 address bytes 4..5 |
| grp_tbl_lo | input | 32 | Group hash table entries 0..31 |
| grp_tbl_hi | input | 32 | Group hash table entries 32..63 |
| filt_ctrl | input | 4 | Enables: bit0 station 0, bit1 station 1, bit2 hash on individual addresses, bit3 broadcast |
| dec_valid | output | 1 | Decision valid, one cycle after `frm_valid` |
| dec_accept | output | 1 | Keep the frame (meaningful while `dec_valid`) |

## Verification
The properties assume that the configuration inputs used to judge a strobe were driven on the cycle before that strobe, since that is the value the shadow registers hold. The station and broadcast properties therefore compare against the previous cycle's inputs and do not fire in the first cycle after reset. The stimulus changes configuration only on a clock before a gap of at least one cycle, then holds it while frames are presented. Frame addresses are drawn from a mix of random values, copies of the programmed stations, the broadcast value and hand-built hash indices, with bit 0 of byte 0 toggled so that both address kinds are exercised.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  localparam int ADDR_W   = 48;
  localparam int SLICE_W  = 6;
  localparam int TBL_W    = 32;
  localparam int LO_W     = 32;
  localparam int HI_W     = ADDR_W - LO_W;
  localparam int NUM_STA  = 2;
  localparam int CTRL_W   = 4;

  // control bit positions
  localparam int CB_STA0  = 0;
  localparam int CB_STA1  = 1;
  localparam int CB_HUNI  = 2;
  localparam int CB_BCAST = 3;

  typedef struct packed {
    logic [NUM_STA-1:0][ADDR_W-1:0] sta;
    logic [TBL_W-1:0]               tbl_hi;
    logic [TBL_W-1:0]               tbl_lo;
    logic [CTRL_W-1:0]              ctrl;
  } rxf_cfg_t;

endpackage

// File: rtl/rxf_cfg_shadow.sv
module rxf_cfg_shadow
  import rxf_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  rxf_cfg_t cfg_in,
  output rxf_cfg_t cfg_q
);

  always_ff @(posedge clk) begin
    if (rst) cfg_q <= '0;
    else     cfg_q <= cfg_in;
  end

endmodule

// File: rtl/rxf_hash_fold.sv
module rxf_hash_fold #(
  parameter int ADDR_W  = 48,
  parameter int SLICE_W = 6
) (
  input  logic [ADDR_W-1:0]  addr,
  output logic [SLICE_W-1:0] idx
);

  localparam int NSLICE = ADDR_W / SLICE_W;

  logic [SLICE_W-1:0] acc [NSLICE+1];

  assign acc[0] = '0;

  for (genvar g = 0; g < NSLICE; g++) begin : g_fold
    assign acc[g+1] = acc[g] ^ addr[g*SLICE_W +: SLICE_W];
  end

  assign idx = acc[NSLICE];

endmodule

// File: rtl/rxf_hash_lookup.sv
module rxf_hash_lookup #(
  parameter int SLICE_W = 6,
  parameter int TBL_W   = 32
) (
  input  logic [SLICE_W-1:0] idx,
  input  logic [TBL_W-1:0]   tbl_lo,
  input  logic [TBL_W-1:0]   tbl_hi,
  output logic               hit
);

  localparam int SEL_W = SLICE_W - 1;

  logic [SEL_W-1:0] bit_sel;
  logic [TBL_W-1:0] word;

  assign bit_sel = idx[SEL_W-1:0];

  always_comb begin
    word = idx[SLICE_W-1] ? tbl_hi : tbl_lo;
    hit  = word[bit_sel];
  end

endmodule

// File: rtl/rxf_station_cmp.sv
module rxf_station_cmp #(
  parameter int ADDR_W  = 48,
  parameter int NUM_STA = 2
) (
  input  logic [ADDR_W-1:0]               addr,
  input  logic [NUM_STA-1:0][ADDR_W-1:0]  sta,
  input  logic [NUM_STA-1:0]              en,
  output logic                            hit
);

  logic [NUM_STA-1:0] each;

  for (genvar s = 0; s < NUM_STA; s++) begin : g_sta
    assign each[s] = en[s] && (addr == sta[s]);
  end

  assign hit = |each;

endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import rxf_pkg::*;
#(
  parameter int LEN_W   = 16,
  parameter int MIN_LEN = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frm_valid,
  input  logic [ADDR_W-1:0] frm_dst,
  input  logic [LEN_W-1:0]  frm_len,
  input  logic [LO_W-1:0]   sta0_lo,
  input  logic [HI_W-1:0]   sta0_hi,
  input  logic [LO_W-1:0]   sta1_lo,
  input  logic [HI_W-1:0]   sta1_hi,
  input  logic [TBL_W-1:0]  grp_tbl_lo,
  input  logic [TBL_W-1:0]  grp_tbl_hi,
  input  logic [CTRL_W-1:0] filt_ctrl,
  output logic              dec_valid,
  output logic              dec_accept
);

  rxf_cfg_t cfg_d, cfg_q;

  always_comb begin
    cfg_d.sta[0] = {sta0_hi, sta0_lo};
    cfg_d.sta[1] = {sta1_hi, sta1_lo};
    cfg_d.tbl_lo = grp_tbl_lo;
    cfg_d.tbl_hi = grp_tbl_hi;
    cfg_d.ctrl   = filt_ctrl;
  end

  rxf_cfg_shadow u_shadow (
    .clk    (clk),
    .rst    (rst),
    .cfg_in (cfg_d),
    .cfg_q  (cfg_q)
  );

  logic               sta_hit;
  logic [SLICE_W-1:0] hidx;
  logic               tbl_hit;
  logic               bcast_hit;
  logic               hash_hit;
  logic               len_ok;
  logic               keep;

  rxf_station_cmp #(.ADDR_W(ADDR_W), .NUM_STA(NUM_STA)) u_sta (
    .addr (frm_dst),
    .sta  (cfg_q.sta),
    .en   ({cfg_q.ctrl[CB_STA1], cfg_q.ctrl[CB_STA0]}),
    .hit  (sta_hit)
  );

  rxf_hash_fold #(.ADDR_W(ADDR_W), .SLICE_W(SLICE_W)) u_fold (
    .addr (frm_dst),
    .idx  (hidx)
  );

  rxf_hash_lookup #(.SLICE_W(SLICE_W), .TBL_W(TBL_W)) u_lookup (
    .idx    (hidx),
    .tbl_lo (cfg_q.tbl_lo),
    .tbl_hi (cfg_q.tbl_hi),
    .hit    (tbl_hit)
  );

  always_comb begin
    bcast_hit = cfg_q.ctrl[CB_BCAST] && (&frm_dst);
    hash_hit  = tbl_hit && (cfg_q.ctrl[CB_HUNI] || frm_dst[0]);
    len_ok    = (frm_len >= LEN_W'(MIN_LEN));
    keep      = len_ok && (sta_hit || bcast_hit || hash_hit);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_valid  <= 1'b0;
      dec_accept <= 1'b0;
    end else begin
      dec_valid  <= frm_valid;
      dec_accept <= frm_valid && keep;
    end
  end

endmodule

// File: rtl/rxf_checker.sv
module rxf_checker
  import rxf_pkg::*;
#(
  parameter int LEN_W   = 16,
  parameter int MIN_LEN = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              frm_valid,
  input logic [ADDR_W-1:0] frm_dst,
  input logic [LEN_W-1:0]  frm_len,
  input logic [LO_W-1:0]   sta0_lo,
  input logic [HI_W-1:0]   sta0_hi,
  input logic [CTRL_W-1:0] filt_ctrl,
  input logic              dec_valid,
  input logic              dec_accept
);

  // R2: strobe produces a decision one cycle later
  p_valid_follows_r2: assert property (@(posedge clk) disable iff (rst)
    frm_valid |=> dec_valid);

  // R2: no decision without a strobe
  p_no_spurious_r2: assert property (@(posedge clk) disable iff (rst)
    !frm_valid |=> !dec_valid);

  // R2: accept only with valid
  p_accept_in_valid_r2: assert property (@(posedge clk) disable iff (rst)
    dec_accept |-> dec_valid);

  // R1: short frames dropped
  p_short_drop_r1: assert property (@(posedge clk) disable iff (rst)
    (frm_valid && frm_len < LEN_W'(MIN_LEN)) |=> !dec_accept);

  // R4: enabled broadcast accepted
  p_bcast_keep_r4: assert property (@(posedge clk) disable iff (rst)
    (frm_valid && !$past(rst) && frm_len >= LEN_W'(MIN_LEN) && (&frm_dst)
     && $past(filt_ctrl[CB_BCAST])) |=> dec_accept);

  // R3: enabled station 0 exact match accepted
  p_sta0_keep_r3: assert property (@(posedge clk) disable iff (rst)
    (frm_valid && !$past(rst) && frm_len >= LEN_W'(MIN_LEN)
     && $past(filt_ctrl[CB_STA0]) && frm_dst == {$past(sta0_hi), $past(sta0_lo)})
    |=> dec_accept);

  // R9: outputs quiet right after reset
  p_reset_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!dec_valid && !dec_accept));

endmodule

bind rx_addr_filter rxf_checker #(.LEN_W(LEN_W), .MIN_LEN(MIN_LEN)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .frm_valid  (frm_valid),
  .frm_dst    (frm_dst),
  .frm_len    (frm_len),
  .sta0_lo    (sta0_lo),
  .sta0_hi    (sta0_hi),
  .filt_ctrl  (filt_ctrl),
  .dec_valid  (dec_valid),
  .dec_accept (dec_accept)
);

// File: tb/rx_addr_filter_test.sv
module rx_addr_filter_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        frm_valid = 1'b0;
  logic [47:0] frm_dst = '0;
  logic [15:0] frm_len = '0;
  logic [31:0] sta0_lo = '0, sta1_lo = '0;
  logic [15:0] sta0_hi = '0, sta1_hi = '0;
  logic [31:0] grp_tbl_lo = '0, grp_tbl_hi = '0;
  logic [3:0]  filt_ctrl = '0;
  logic        dec_valid, dec_accept;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  rx_addr_filter uut (
    .clk(clk), .rst(rst), .frm_valid(frm_valid), .frm_dst(frm_dst),
    .frm_len(frm_len), .sta0_lo(sta0_lo), .sta0_hi(sta0_hi),
    .sta1_lo(sta1_lo), .sta1_hi(sta1_hi), .grp_tbl_lo(grp_tbl_lo),
    .grp_tbl_hi(grp_tbl_hi), .filt_ctrl(filt_ctrl),
    .dec_valid(dec_valid), .dec_accept(dec_accept)
  );

  function automatic int unsigned fold_idx(logic [47:0] a);
    int unsigned h = 0;
    for (int k = 0; k < 48; k++)
      if (a[k]) h = h ^ (32'd1 << (k % 6));
    return h;
  endfunction

  function automatic logic model_keep(logic [47:0] a, logic [15:0] len);
    int unsigned h;
    logic tb;
    if (len < 16'd12) return 1'b0;
    if (filt_ctrl[0] && a == {sta0_hi, sta0_lo}) return 1'b1;
    if (filt_ctrl[1] && a == {sta1_hi, sta1_lo}) return 1'b1;
    if (filt_ctrl[3] && a == {48{1'b1}}) return 1'b1;
    h  = fold_idx(a);
    tb = (h > 31) ? grp_tbl_hi[h-32] : grp_tbl_lo[h];
    return tb && (filt_ctrl[2] || a[0]);
  endfunction

  task automatic check(string req, logic got, logic exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  // assumes caller is at a negedge; config already held one cycle
  task automatic send(string req, logic [47:0] a, logic [15:0] len, logic exp);
    frm_dst   = a;
    frm_len   = len;
    frm_valid = 1'b1;
    @(negedge clk);
    frm_valid = 1'b0;
    check({req, " valid"}, dec_valid, 1'b1);
    check(req, dec_accept, exp);
  endtask

  task automatic set_cfg(logic [3:0] c, logic [31:0] tl, logic [31:0] th);
    filt_ctrl  = c;
    grp_tbl_lo = tl;
    grp_tbl_hi = th;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [47:0] a;
    logic [15:0] l;
    // R9: reset state, config fully open during reset
    sta0_lo = 32'h33221100; sta0_hi = 16'h5544;
    sta1_lo = 32'hddccbbaa; sta1_hi = 16'hffee;
    filt_ctrl = 4'hf; grp_tbl_lo = '1; grp_tbl_hi = '1;
    repeat (3) @(negedge clk);
    frm_valid = 1'b1; frm_dst = '1; frm_len = 16'd64;
    @(negedge clk);
    check("R9 valid in reset", dec_valid, 1'b0);
    check("R9 accept in reset", dec_accept, 1'b0);
    // R8: first strobe after reset sees zeroed shadow config
    rst = 1'b0;
    frm_valid = 1'b1;
    @(negedge clk);
    frm_valid = 1'b0;
    check("R8 first-cycle valid", dec_valid, 1'b1);
    check("R8 first-cycle drop", dec_accept, 1'b0);
    send("R8 config now live", '1, 16'd64, 1'b1);
    // R2: no strobe, no decision
    @(negedge clk);
    check("R2 idle valid", dec_valid, 1'b0);

    // R1 length boundary
    set_cfg(4'b1000, '0, '0);
    send("R1 len 11 bcast", '1, 16'd11, 1'b0);
    send("R1 len 12 bcast", '1, 16'd12, 1'b1);
    // R4 broadcast disabled
    set_cfg(4'b0000, '0, '0);
    send("R4 bcast off", '1, 16'd64, 1'b0);
    // R3 stations
    set_cfg(4'b0001, '0, '0);
    send("R3 sta0 on", 48'h554433221100, 16'd60, 1'b1);
    send("R3 sta1 off", 48'hffeeddccbbaa, 16'd60, 1'b0);
    send("R3 sta0 near miss", 48'h554433221101, 16'd60, 1'b0);
    set_cfg(4'b0010, '0, '0);
    send("R3 sta1 on", 48'hffeeddccbbaa, 16'd60, 1'b1);
    send("R3 sta0 off", 48'h554433221100, 16'd60, 1'b0);
    // R5/R6 hash: group 0 = 0x25 -> index 37 -> hi bit 5
    set_cfg(4'b0000, '0, 32'h20);
    send("R6 hi bit5", 48'h25, 16'd60, 1'b1);
    set_cfg(4'b0000, 32'h20, 32'h10);
    send("R6 lo bit5 not hi", 48'h25, 16'd60, 1'b0);
    // index 5: lo bit 5
    send("R6 lo bit5", 48'h05, 16'd60, 1'b1);
    // R5: same index reached from group 7 xor group 0
    send("R5 fold groups", {6'h04, 36'h0, 6'h01}, 16'd60, 1'b1);
    // R7: individual address, index 37 via group 1
    set_cfg(4'b0000, '0, 32'h20);
    send("R7 unicast hash gated", 48'h25 << 6, 16'd60, 1'b0);
    set_cfg(4'b0100, '0, 32'h20);
    send("R7 unicast hash enabled", 48'h25 << 6, 16'd60, 1'b1);

    // constrained random
    void'($urandom(32'd1234));
    for (int f = 0; f < 400; f++) begin
      if (f % 16 == 0) begin
        sta0_lo = $urandom; sta0_hi = 16'($urandom);
        sta1_lo = $urandom; sta1_hi = 16'($urandom);
        set_cfg(4'($urandom), $urandom, $urandom);
      end
      case ($urandom % 4)
        0: a = {16'($urandom), $urandom};
        1: a = {sta0_hi, sta0_lo};
        2: a = {sta1_hi, sta1_lo};
        default: a = '1;
      endcase
      if ($urandom % 5 == 0) a[0] = ~a[0];
      l = ($urandom % 3 == 0) ? 16'($urandom % 16) : 16'd64;
      send("R1/R3/R4/R6/R7 random", a, l, model_keep(a, l));
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule